// File: doc/BRIEF.md
# Configuration Sequencing Controller

This block steps a programmable device through its bring-up: initialization, configuration, start-up and normal operation. It watches a power-on reset, a shared open-drain style ready line, active-low reset and program pins, four mode pins, a strobe per configuration clock, a loaded length value, an end-of-configuration-frame flag and a frame-error flag. From these it drives the ready line low, two configuration-busy indicators, a done flag, a memory-clear request, a release for the core reset and an I/O enable.

The ready line is wire-ANDed with other devices, so any party can hold every device in initialization. Master modes wait longer before configuration so that chained slaves are ready. Aborts depend on the phase: during configuration the reset pin, the program pin or a frame error restart initialization; once configuration has completed only the program pin does. Frame parsing, word assembly and the configuration memory are outside the block.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: `phase` encodes initialization as 0, configuration as 1, start-up as 2 and operation as 3; while `por_n` is low and for at least POR_CYC clock edges after it rises, `phase` is 0.
- R2: In phases 0 and 1, `busy_hi` is 1, `busy_lo` is 0 and `cfg_done` is 0; in phases 2 and 3, `busy_hi` is 0, `busy_lo` is 1 and `cfg_done` is 1.
- R3: `mem_clr_req` is high in phase 0 for the first POR_CYC edges after power-on reset and for CLR_CYC edges after each return to phase 0, and low otherwise.
- R4: `rdy_pull_low` is high in phase 0 while the memory clear runs or while the synchronized reset or program pin is low, and low in every other phase.
- R5: The block leaves phase 0 only after the synchronized ready line, reset pin and program pin are all high with no clear running for two consecutive edges; `mode_lat` takes `mode_pins` on the second such edge. In slave mode (`mode_pins[0]`=0) phase 1 is reached on the fourth edge after the ready line is released.
- R6: In master mode (`mode_pins[0]`=1) entry to phase 1 needs MASTER_EXTRA further qualifying edges, reaching phase 1 on the tenth edge after release with the default of six.
- R7: On entry to phase 1 the length count is zero and rises by one per edge with `cfg_clk_stb` high; phase 2 begins on the edge where the count equals `load_len` and `end_frame` is high now or was high earlier in this configuration.
- R8: In phase 1, a low synchronized reset or program pin, or `frame_err` high, returns to phase 0, and phase 1 is not re-entered while either pin stays low.
- R9: Phase 2 lasts START_CYC edges, then phase 3; `io_en` and `core_rst_rel` are high only in phases 2 and 3, and phase 3 is never entered directly from phase 1.
- R10: In phases 2 and 3 a low synchronized program pin returns to phase 0 on the third edge after it falls; the reset pin has no effect there.
- R11: When `keep_cfg_mem` is high at a return to phase 0 and a configuration has completed since power-on, no memory clear is requested during that initialization.
- R12: The reset pin, program pin and ready line each pass through a two-flop synchronizer, so a change acts on the phase no earlier than the second edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rdy_sense | input | 1 | Sensed level of the shared ready line |
| rst_pin_n | input | 1 | Reset pin, active low |
| prog_pin_n | input | 1 | Program pin, active low |
| mode_pins | input | 4 | Mode select; bit 0 set means master |
| cfg_clk_stb | input | 1 | One pulse per configuration clock cycle |
| load_len | input | LEN_W | Length count loaded from the bitstream |
| end_frame | input | 1 | End-of-configuration frame written |
| frame_err | input | 1 | Bit error seen in the incoming data |
| keep_cfg_mem | input | 1 | Skip clearing memory on reconfiguration |
| rdy_pull_low | output | 1 | Drive the shared ready line low |
| busy_hi | output | 1 | High while initializing or configuring |
| busy_lo | output | 1 | Low while initializing or configuring |
| cfg_done | output | 1 | Configuration complete |
| mem_clr_req | output | 1 | Request to clear configuration memory |
| core_rst_rel | output | 1 | Release of the internal core reset |
| io_en | output | 1 | Enable of the user I/Os |
| mode_lat | output | 4 | Mode pins captured on entry to configuration |
| phase | output | 2 | Current phase code |

## Verification
The bench builds the block with POR_CYC=5, CLR_CYC=3, START_CYC=2, LEN_W=6 and MASTER_EXTRA=6. Short clear and start-up windows let a few thousand random cycles pass through many aborts, reconfigurations and keep-memory restarts, while the default master wait keeps the four-versus-ten edge entry timing exact. A six-bit length with loads below eight makes the equal-count completion, early end-of-frame and wrap cases all frequent.

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl #(
  parameter int LEN_W        = 16,
  parameter int POR_CYC      = 64,
  parameter int CLR_CYC      = 32,
  parameter int MASTER_EXTRA = 6,
  parameter int START_CYC    = 4
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rdy_sense,
  input  logic             rst_pin_n,
  input  logic             prog_pin_n,
  input  logic [3:0]       mode_pins,
  input  logic             cfg_clk_stb,
  input  logic [LEN_W-1:0] load_len,
  input  logic             end_frame,
  input  logic             frame_err,
  input  logic             keep_cfg_mem,
  output logic             rdy_pull_low,
  output logic             busy_hi,
  output logic             busy_lo,
  output logic             cfg_done,
  output logic             mem_clr_req,
  output logic             core_rst_rel,
  output logic             io_en,
  output logic [3:0]       mode_lat,
  output logic [1:0]       phase
);
  localparam int HOLD_W = $clog2((POR_CYC > CLR_CYC ? POR_CYC : CLR_CYC) + 1);
  localparam int HI_W   = $clog2(MASTER_EXTRA + 3);
  localparam int ST_W   = $clog2(START_CYC + 1);
  localparam logic [HOLD_W-1:0] POR_LD    = HOLD_W'(POR_CYC);
  localparam logic [HOLD_W-1:0] CLR_LD    = HOLD_W'(CLR_CYC);
  localparam logic [HI_W-1:0]   HI_SAMPLE = HI_W'(1);
  localparam logic [HI_W-1:0]   HI_LAST   = HI_W'(MASTER_EXTRA + 1);
  localparam logic [ST_W-1:0]   ST_LAST   = ST_W'(START_CYC - 1);

  typedef enum logic [1:0] {S_INIT = 2'd0, S_CFG = 2'd1, S_START = 2'd2, S_RUN = 2'd3} phase_t;

  phase_t            st;
  logic [1:0]        rst_sy, prog_sy, rdy_sy;
  logic [HOLD_W-1:0] hold;
  logic [HI_W-1:0]   hi;
  logic [LEN_W-1:0]  len_cnt;
  logic [ST_W-1:0]   st_cnt;
  logic              eoc_seen, cfg_once;

  wire rst_ok   = rst_sy[1];
  wire prog_ok  = prog_sy[1];
  wire rdy_ok   = rdy_sy[1];
  wire clearing = hold != '0;
  wire qual     = rdy_ok & rst_ok & prog_ok & ~clearing;
  wire in_init  = st == S_INIT;
  wire cfg_end  = (len_cnt == load_len) & (eoc_seen | end_frame);
  wire go_init  = ((st == S_CFG) & (~rst_ok | ~prog_ok | frame_err)) |
                  (((st == S_START) | (st == S_RUN)) & ~prog_ok);
  wire to_cfg   = qual & (((hi == HI_SAMPLE) & ~mode_pins[0]) |
                          ((hi == HI_LAST) & mode_lat[0]));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_sy   <= '0;
      prog_sy  <= '0;
      rdy_sy   <= '0;
      st       <= S_INIT;
      hold     <= POR_LD;
      hi       <= '0;
      mode_lat <= '0;
      len_cnt  <= '0;
      st_cnt   <= '0;
      eoc_seen <= 1'b0;
      cfg_once <= 1'b0;
    end else begin
      rst_sy  <= {rst_sy[0], rst_pin_n};
      prog_sy <= {prog_sy[0], prog_pin_n};
      rdy_sy  <= {rdy_sy[0], rdy_sense};
      if (go_init) begin
        st   <= S_INIT;
        hold <= (keep_cfg_mem && cfg_once) ? '0 : CLR_LD;
        hi   <= '0;
      end else begin
        unique case (st)
          S_INIT: begin
            if (clearing) hold <= hold - 1'b1;
            if (qual && hi == HI_SAMPLE) mode_lat <= mode_pins;
            if (to_cfg) begin
              st       <= S_CFG;
              hi       <= '0;
              len_cnt  <= '0;
              eoc_seen <= 1'b0;
            end else if (qual) begin
              hi <= hi + 1'b1;
            end else begin
              hi <= '0;
            end
          end
          S_CFG: begin
            if (cfg_end) begin
              st       <= S_START;
              st_cnt   <= '0;
              cfg_once <= 1'b1;
            end else begin
              if (cfg_clk_stb) len_cnt <= len_cnt + 1'b1;
              if (end_frame) eoc_seen <= 1'b1;
            end
          end
          S_START: begin
            if (st_cnt == ST_LAST) st <= S_RUN;
            else st_cnt <= st_cnt + 1'b1;
          end
          S_RUN: ;
          default: st <= S_INIT;
        endcase
      end
    end
  end

  assign phase        = st;
  assign busy_hi      = (st == S_INIT) | (st == S_CFG);
  assign busy_lo      = ~busy_hi;
  assign cfg_done     = ~busy_hi;
  assign io_en        = ~busy_hi;
  assign core_rst_rel = ~busy_hi;
  assign mem_clr_req  = in_init & clearing;
  assign rdy_pull_low = in_init & (clearing | ~rst_ok | ~prog_ok);

  assert_cfg_entry_R5: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_CFG && $past(st) == S_INIT) |-> ($past(rdy_ok) && $past(rst_ok) && $past(prog_ok)))
    else $error("configuration entered without qualified pins");

  assert_len_zero_R7: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_CFG && $past(st) == S_INIT) |-> len_cnt == '0)
    else $error("length count not cleared on entry");

  assert_start_len_R7: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_START && $past(st) == S_CFG) |->
      ($past(len_cnt) == $past(load_len) && ($past(eoc_seen) || $past(end_frame))))
    else $error("start-up without length match and end frame");

  assert_err_abort_R8: assert property (@(posedge clk) disable iff (!por_n)
    ($past(st) == S_CFG && $past(frame_err)) |-> st == S_INIT)
    else $error("frame error did not abort");

  assert_no_skip_R9: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_CFG) |=> (st != S_RUN))
    else $error("operation entered without start-up");

  assert_rst_ignored_R10: assert property (@(posedge clk) disable iff (!por_n)
    ($past(st) == S_RUN && $past(prog_ok)) |-> st == S_RUN)
    else $error("operation left without program pin");

  assert_skip_clear_R11: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_INIT && $past(st) != S_INIT && $past(keep_cfg_mem) && $past(cfg_once)) |-> !mem_clr_req)
    else $error("memory clear requested despite keep option");
endmodule

// File: tb/cfg_seq_ctrl_bench.sv
module cfg_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 6, POR = 5, CLR = 3, EXTRA = 6, STC = 2;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_pin_n = 1'b1, prog_pin_n = 1'b1, ext_hold = 1'b0;
  logic [3:0] mode_pins = '0;
  logic cfg_clk_stb = 1'b0, end_frame = 1'b0, frame_err = 1'b0, keep_cfg_mem = 1'b0;
  logic [LEN_W-1:0] load_len = '0;
  logic rdy_pull_low, busy_hi, busy_lo, cfg_done, mem_clr_req, core_rst_rel, io_en;
  logic [3:0] mode_lat;
  logic [1:0] phase;
  wire rdy_sense = ~rdy_pull_low & ~ext_hold;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_seq_ctrl #(.LEN_W(LEN_W), .POR_CYC(POR), .CLR_CYC(CLR),
                 .MASTER_EXTRA(EXTRA), .START_CYC(STC)) u_cfg_seq_ctrl (
    .clk(clk), .por_n(por_n), .rdy_sense(rdy_sense), .rst_pin_n(rst_pin_n),
    .prog_pin_n(prog_pin_n), .mode_pins(mode_pins), .cfg_clk_stb(cfg_clk_stb),
    .load_len(load_len), .end_frame(end_frame), .frame_err(frame_err),
    .keep_cfg_mem(keep_cfg_mem), .rdy_pull_low(rdy_pull_low), .busy_hi(busy_hi),
    .busy_lo(busy_lo), .cfg_done(cfg_done), .mem_clr_req(mem_clr_req),
    .core_rst_rel(core_rst_rel), .io_en(io_en), .mode_lat(mode_lat), .phase(phase));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model built from the requirements
  int m_ph, m_hold, m_hi, m_need, m_st;
  logic [1:0] m_rs, m_ps, m_is;
  logic [3:0] m_mode;
  logic [LEN_W-1:0] m_len;
  bit m_eoc, m_once;
  int t_cnt, t_need;

  function automatic bit f_pull(int ph, int hold, logic r, logic p);
    return ph == 0 && (hold > 0 || !r || !p);
  endfunction
  function automatic bit f_clear(int ph, int hold);
    return ph == 0 && hold > 0;
  endfunction

  wire m_sense = ~f_pull(m_ph, m_hold, m_rs[1], m_ps[1]) & ~ext_hold;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_ph <= 0; m_hold <= POR; m_hi <= 0; m_need <= 2; m_st <= 0;
      m_rs <= '0; m_ps <= '0; m_is <= '0; m_mode <= '0; m_len <= '0;
      m_eoc <= 1'b0; m_once <= 1'b0;
    end else begin
      m_rs <= {m_rs[0], rst_pin_n};
      m_ps <= {m_ps[0], prog_pin_n};
      m_is <= {m_is[0], m_sense};
      if ((m_ph == 1 && (!m_rs[1] || !m_ps[1] || frame_err)) || (m_ph >= 2 && !m_ps[1])) begin
        m_ph <= 0; m_hi <= 0;
        m_hold <= (keep_cfg_mem && m_once) ? 0 : CLR;
      end else if (m_ph == 0) begin
        if (m_hold > 0) m_hold <= m_hold - 1;
        if (m_is[1] && m_rs[1] && m_ps[1] && m_hold == 0) begin
          t_cnt = m_hi + 1;
          t_need = (t_cnt == 2) ? (mode_pins[0] ? 2 + EXTRA : 2) : m_need;
          if (t_cnt == 2) begin m_need <= t_need; m_mode <= mode_pins; end
          if (t_cnt >= 2 && t_cnt == t_need) begin
            m_ph <= 1; m_hi <= 0; m_len <= '0; m_eoc <= 1'b0;
          end else m_hi <= t_cnt;
        end else m_hi <= 0;
      end else if (m_ph == 1) begin
        if (m_len == load_len && (m_eoc || end_frame)) begin
          m_ph <= 2; m_st <= 0; m_once <= 1'b1;
        end else begin
          if (cfg_clk_stb) m_len <= m_len + 1'b1;
          if (end_frame) m_eoc <= 1'b1;
        end
      end else if (m_ph == 2) begin
        if (m_st == STC - 1) m_ph <= 3; else m_st <= m_st + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk("R1 phase", 32'(phase), 32'(m_ph));
      chk("R2 busy/done", {29'd0, busy_hi, busy_lo, cfg_done},
          (m_ph < 2) ? 32'b100 : 32'b011);
      chk("R3 mem clear", 32'(mem_clr_req), 32'(f_clear(m_ph, m_hold)));
      chk("R4 ready pull", 32'(rdy_pull_low), 32'(f_pull(m_ph, m_hold, m_rs[1], m_ps[1])));
      chk("R5 mode latch", 32'(mode_lat), 32'(m_mode));
      chk("R9 io/core release", {30'd0, io_en, core_rst_rel}, (m_ph >= 2) ? 32'b11 : 32'b00);
    end
  end

  task automatic wait_phase(input int target, input int limit, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (phase != 2'(target) && n < limit);
  endtask

  int n;
  bit bad;

  initial begin
    void'($urandom(32'h0c0f_1a57));
    repeat (3) @(negedge clk);
    chk("R1 reset phase", 32'(phase), 0);
    chk("R3 reset clear", 32'(mem_clr_req), 1);
    chk("R4 reset pull", 32'(rdy_pull_low), 1);
    chk("R2 reset done", 32'(cfg_done), 0);

    ext_hold = 1'b1;
    por_n = 1'b1;
    repeat (POR + 6) @(negedge clk);
    chk("R5 held by external low", 32'(phase), 0);
    chk("R3 clear ends after power-on delay", 32'(mem_clr_req), 0);

    mode_pins = 4'b0110;
    ext_hold = 1'b0;
    wait_phase(1, 60, n);
    chk("R5 R12 slave entry edges", 32'(n), 4);
    chk("R5 mode captured", 32'(mode_lat), 32'h6);

    load_len = 6'd5; cfg_clk_stb = 1'b1;
    repeat (5) @(negedge clk);
    cfg_clk_stb = 1'b0;
    @(negedge clk);
    chk("R7 no completion without end frame", 32'(phase), 1);
    end_frame = 1'b1;
    @(negedge clk);
    end_frame = 1'b0;
    chk("R7 start-up after length and end frame", 32'(phase), 2);
    chk("R9 io enabled in start-up", 32'(io_en), 1);
    repeat (STC) @(negedge clk);
    chk("R9 operation after start-up", 32'(phase), 3);

    rst_pin_n = 1'b0;
    repeat (8) @(negedge clk);
    chk("R10 reset pin ignored", 32'(phase), 3);
    rst_pin_n = 1'b1;
    ext_hold = 1'b1;
    prog_pin_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 program pin not yet seen", 32'(phase), 3);
    @(negedge clk);
    chk("R10 program pin returns to init", 32'(phase), 0);
    chk("R3 clear on reinit", 32'(mem_clr_req), 1);
    prog_pin_n = 1'b1;

    mode_pins = 4'b0011;
    repeat (CLR + 6) @(negedge clk);
    ext_hold = 1'b0;
    wait_phase(1, 60, n);
    chk("R6 master entry edges", 32'(n), 10);
    chk("R6 master mode captured", 32'(mode_lat), 32'h3);

    frame_err = 1'b1;
    @(negedge clk);
    frame_err = 1'b0;
    chk("R8 frame error abort", 32'(phase), 0);

    mode_pins = 4'b0000;
    wait_phase(1, 80, n);
    chk("R8 reconfig after error", 32'(phase), 1);
    rst_pin_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset pin abort", 32'(phase), 0);
    repeat (20) @(negedge clk);
    chk("R8 held while reset low", 32'(phase), 0);
    rst_pin_n = 1'b1;
    wait_phase(1, 80, n);
    chk("R8 reconfig after reset release", 32'(phase), 1);

    keep_cfg_mem = 1'b1;
    prog_pin_n = 1'b0;
    bad = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (mem_clr_req) bad = 1'b1;
    end
    chk("R11 in init with keep option", 32'(phase), 0);
    chk("R11 no clear with keep option", 32'(bad), 0);
    prog_pin_n = 1'b1;
    keep_cfg_mem = 1'b0;

    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (i == 1800) por_n = 1'b0;
      if (i == 1802) por_n = 1'b1;
      load_len = 6'($urandom_range(0, 7));
      cfg_clk_stb = $urandom_range(0, 1) == 1;
      end_frame = $urandom_range(0, 15) == 0;
      frame_err = $urandom_range(0, 299) == 0;
      if (rst_pin_n) rst_pin_n = $urandom_range(0, 149) != 0;
      else rst_pin_n = $urandom_range(0, 4) == 0;
      if (prog_pin_n) prog_pin_n = $urandom_range(0, 149) != 0;
      else prog_pin_n = $urandom_range(0, 4) == 0;
      if (ext_hold) ext_hold = $urandom_range(0, 5) != 0;
      else ext_hold = $urandom_range(0, 99) == 0;
      if ($urandom_range(0, 49) == 0) mode_pins = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 99) == 0) keep_cfg_mem = ~keep_cfg_mem;
    end

    @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule